// File: doc/BRIEF.md
# Pipelined Pre-Add Multiply-Accumulate Slice

This block is a signed arithmetic slice. It first adds or subtracts two 25-bit operands. It multiplies that sum by an 18-bit operand. A 48-bit post-adder then combines the product with a second operand, called Z, using one of four equations. Z can be zero, a cascade input from a neighbouring slice, the slice's own registered result, or a 48-bit C operand. Selecting the registered result as Z turns the slice into an accumulator. Selecting C restarts the accumulation from a fresh offset.

A 5-bit mode word controls the slice. It travels down the pipeline together with its operands, so a mode change takes effect only on the operands presented with it. There are four register stages, and each has its own clock enable. The full 48-bit result drives a cascade output that can feed a following slice. A parameterised upper slice of the result forms the external output.

Top module: `preadd_mac_slice`

## Requirements
- R1: After reset, every pipeline register is zero, so `p_out` and `casc_out` read zero.
- R2: With all four enables high, a result appears on `casc_out` after the 4th rising clock edge that follows the operands being applied. Before that edge the output still reflects the earlier operands.
- R3: `mode[4]` sets the pre-adder. A value of 0 forms (A+D)×B and a value of 1 forms (A−D)×B. All operands are signed two's complement, and the pre-add is one bit wider than A, so it cannot overflow.
- R4: `mode[1:0]` sets the post-adder equation, with M as the product: 0 gives Z+M, 1 gives M−Z, 2 gives −(Z+M+1), which is the bitwise inverse of Z+M, and 3 gives Z−M.
- R5: `mode[3:2]` sets the Z source: 0 selects zero, 1 selects `casc_in`, 2 selects the slice's own registered result, and 3 selects the C operand. `casc_in` is sampled at the same edge that loads the result register.
- R6: Presenting Z=C once and then Z=own result on each following cycle yields C + A×B, and then adds A×B again on every further cycle.
- R7: The mode word and C are delayed along with their operands. Operand sets applied on back-to-back cycles with different modes each produce their own result, one per cycle.
- R8: The post-adder wraps modulo 2^48 and does not saturate.
- R9: An enable that is low makes its stage hold its value while later stages keep running. The four enables are `en_opnd` for the operand stage, `en_pre` for the pre-add stage, `en_mul` for the product stage and `en_out` for the result stage.
- R10: `casc_out` carries the full 48-bit result, and `p_out` carries bits 47 down to SHIFT of that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_opnd | input | 1 | Enable for the operand register stage |
| en_pre | input | 1 | Enable for the pre-add register stage |
| en_mul | input | 1 | Enable for the product register stage |
| en_out | input | 1 | Enable for the result register stage |
| a_in | input | 25 | Signed pre-adder operand A |
| d_in | input | 25 | Signed pre-adder operand D |
| b_in | input | 18 | Signed multiplier operand B |
| c_in | input | 48 | Signed post-adder operand C |
| mode | input | 5 | [4] pre-subtract, [3:2] Z source, [1:0] equation |
| casc_in | input | 48 | Cascade input from a preceding slice |
| casc_out | output | 48 | Full registered result |
| p_out | output | 48-SHIFT | Result bits 47 down to SHIFT |

## Verification
A vector table applies one operand set at a time and holds it for the full pipeline depth. The table covers both pre-adder signs, every post-adder equation and every Z source apart from feedback. It also includes full-scale negative operands, to separate correct sign extension from zero extension, and a C value near the positive limit, to show wrap-around. The same vectors are then streamed on consecutive cycles, which exposes any mode or C value that drifts out of step with its data. A fed-back accumulation run separates restart from accumulate. Enable tests drop one stage at a time, to show that the gated stage holds while the stages after it keep running. A second instance with a nonzero output shift checks the output slice.

// File: rtl/pmac_pkg.sv
package pmac_pkg;

    typedef enum logic [1:0] {
        ALU_ADD     = 2'd0,
        ALU_NEG_Z   = 2'd1,
        ALU_NOT_SUM = 2'd2,
        ALU_SUB     = 2'd3
    } alu_op_e;

    typedef enum logic [1:0] {
        ZS_ZERO     = 2'd0,
        ZS_CASC     = 2'd1,
        ZS_FEEDBACK = 2'd2,
        ZS_CIN      = 2'd3
    } zsel_e;

    typedef struct packed {
        zsel_e   zsel;
        alu_op_e op;
    } alu_ctl_t;

    typedef struct packed {
        logic     pre_sub;
        alu_ctl_t alu;
    } ctrl_t;

    function automatic ctrl_t decode_mode(input logic [4:0] m);
        ctrl_t c;
        c.pre_sub  = m[4];
        c.alu.zsel = zsel_e'(m[3:2]);
        c.alu.op   = alu_op_e'(m[1:0]);
        return c;
    endfunction

endpackage

// File: rtl/pmac_front.sv
module pmac_front
    import pmac_pkg::*;
#(
    parameter int AW = 25,
    parameter int BW = 18,
    parameter int PW = 48,
    localparam int SW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_opnd,
    input  logic          en_pre,
    input  logic [AW-1:0] a_i,
    input  logic [AW-1:0] d_i,
    input  logic [BW-1:0] b_i,
    input  logic [PW-1:0] c_i,
    input  ctrl_t         ctrl_i,
    output logic [SW-1:0] sum_o,
    output logic [BW-1:0] b_o,
    output logic [PW-1:0] c_o,
    output alu_ctl_t      alu_o
);

    typedef struct packed {
        logic [AW-1:0] a1;
        logic [AW-1:0] d1;
        logic [BW-1:0] b1;
        logic [PW-1:0] c1;
        ctrl_t         ctl1;
        logic [SW-1:0] sum2;
        logic [BW-1:0] b2;
        logic [PW-1:0] c2;
        alu_ctl_t      alu2;
    } front_t;

    front_t st_d, st_q;
    logic signed [SW-1:0] a_ext, d_ext;

    always_comb begin
        st_d  = st_q;
        a_ext = {st_q.a1[AW-1], st_q.a1};
        d_ext = {st_q.d1[AW-1], st_q.d1};
        if (en_opnd) begin
            st_d.a1   = a_i;
            st_d.d1   = d_i;
            st_d.b1   = b_i;
            st_d.c1   = c_i;
            st_d.ctl1 = ctrl_i;
        end
        if (en_pre) begin
            st_d.sum2 = st_q.ctl1.pre_sub ? (a_ext - d_ext) : (a_ext + d_ext);
            st_d.b2   = st_q.b1;
            st_d.c2   = st_q.c1;
            st_d.alu2 = st_q.ctl1.alu;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sum_o = st_q.sum2;
    assign b_o   = st_q.b2;
    assign c_o   = st_q.c2;
    assign alu_o = st_q.alu2;

endmodule

// File: rtl/pmac_mult.sv
module pmac_mult
    import pmac_pkg::*;
#(
    parameter int SW = 26,
    parameter int BW = 18,
    parameter int PW = 48,
    localparam int MW = SW + BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_mul,
    input  logic [SW-1:0] sum_i,
    input  logic [BW-1:0] b_i,
    input  logic [PW-1:0] c_i,
    input  alu_ctl_t      alu_i,
    output logic [PW-1:0] mul_o,
    output logic [PW-1:0] c_o,
    output alu_ctl_t      alu_o
);

    typedef struct packed {
        logic [PW-1:0] mul;
        logic [PW-1:0] c;
        alu_ctl_t      alu;
    } mult_t;

    mult_t st_d, st_q;
    logic signed [MW-1:0] prod;
    logic [PW-1:0] prod_ext;

    assign prod = $signed(sum_i) * $signed(b_i);

    generate
        if (MW < PW) begin : g_extend
            assign prod_ext = {{(PW-MW){prod[MW-1]}}, prod};
        end else begin : g_trunc
            assign prod_ext = prod[PW-1:0];
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (en_mul) begin
            st_d.mul = prod_ext;
            st_d.c   = c_i;
            st_d.alu = alu_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mul_o = st_q.mul;
    assign c_o   = st_q.c;
    assign alu_o = st_q.alu;

endmodule

// File: rtl/pmac_post.sv
module pmac_post
    import pmac_pkg::*;
#(
    parameter int PW = 48
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_out,
    input  logic [PW-1:0] mul_i,
    input  logic [PW-1:0] c_i,
    input  logic [PW-1:0] casc_i,
    input  alu_ctl_t      alu_i,
    output logic [PW-1:0] p_o
);

    typedef struct packed {
        logic [PW-1:0] p;
    } post_t;

    post_t st_d, st_q;
    logic [PW-1:0] z_op;
    logic [PW-1:0] alu_res;

    always_comb begin
        unique case (alu_i.zsel)
            ZS_ZERO:     z_op = '0;
            ZS_CASC:     z_op = casc_i;
            ZS_FEEDBACK: z_op = st_q.p;
            default:     z_op = c_i;
        endcase
        unique case (alu_i.op)
            ALU_ADD:     alu_res = z_op + mul_i;
            ALU_NEG_Z:   alu_res = mul_i - z_op;
            ALU_NOT_SUM: alu_res = ~(z_op + mul_i);
            default:     alu_res = z_op - mul_i;
        endcase
        st_d = st_q;
        if (en_out) st_d.p = alu_res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign p_o = st_q.p;

endmodule

// File: rtl/preadd_mac_slice.sv
module preadd_mac_slice
    import pmac_pkg::*;
#(
    parameter int AW    = 25,
    parameter int BW    = 18,
    parameter int PW    = 48,
    parameter int SHIFT = 0,
    localparam int SW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_opnd,
    input  logic             en_pre,
    input  logic             en_mul,
    input  logic             en_out,
    input  logic [AW-1:0]    a_in,
    input  logic [AW-1:0]    d_in,
    input  logic [BW-1:0]    b_in,
    input  logic [PW-1:0]    c_in,
    input  logic [4:0]       mode,
    input  logic [PW-1:0]    casc_in,
    output logic [PW-1:0]    casc_out,
    output logic [PW-SHIFT-1:0] p_out
);

    logic [SW-1:0] sum_q;
    logic [BW-1:0] b_q;
    logic [PW-1:0] c_pre_q;
    alu_ctl_t      alu_pre_q;
    logic [PW-1:0] mul_q;
    logic [PW-1:0] c_mul_q;
    alu_ctl_t      ctrl_m;
    logic [PW-1:0] p_q;

    pmac_front #(.AW(AW), .BW(BW), .PW(PW)) u_front (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_opnd (en_opnd),
        .en_pre  (en_pre),
        .a_i     (a_in),
        .d_i     (d_in),
        .b_i     (b_in),
        .c_i     (c_in),
        .ctrl_i  (decode_mode(mode)),
        .sum_o   (sum_q),
        .b_o     (b_q),
        .c_o     (c_pre_q),
        .alu_o   (alu_pre_q)
    );

    pmac_mult #(.SW(SW), .BW(BW), .PW(PW)) u_mult (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_mul (en_mul),
        .sum_i  (sum_q),
        .b_i    (b_q),
        .c_i    (c_pre_q),
        .alu_i  (alu_pre_q),
        .mul_o  (mul_q),
        .c_o    (c_mul_q),
        .alu_o  (ctrl_m)
    );

    pmac_post #(.PW(PW)) u_post (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_out (en_out),
        .mul_i  (mul_q),
        .c_i    (c_mul_q),
        .casc_i (casc_in),
        .alu_i  (ctrl_m),
        .p_o    (p_q)
    );

    assign casc_out = p_q;

    generate
        if (SHIFT == 0) begin : g_full
            assign p_out = p_q;
        end else begin : g_slice
            assign p_out = p_q[PW-1:SHIFT];
        end
    endgenerate

endmodule

// File: rtl/pmac_checker.sv
module pmac_checker
    import pmac_pkg::*;
#(
    parameter int PW = 48
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en_mul,
    input logic          en_out,
    input alu_ctl_t      ctrl_m,
    input logic [PW-1:0] mul_q,
    input logic [PW-1:0] casc_out
);

    a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (casc_out == '0 && mul_q == '0));

    a_r9_hold_out: assert property (@(posedge clk) disable iff (!rst_n)
        !en_out |=> $stable(casc_out));

    a_r9_hold_mult: assert property (@(posedge clk) disable iff (!rst_n)
        !en_mul |=> $stable(mul_q));

    a_r4_add_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (en_out && ctrl_m.op == ALU_ADD && ctrl_m.zsel == ZS_ZERO)
        |=> casc_out == $past(mul_q));

    a_r4_not_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (en_out && ctrl_m.op == ALU_NOT_SUM && ctrl_m.zsel == ZS_ZERO)
        |=> casc_out == ~$past(mul_q));

    a_r4_sub_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (en_out && ctrl_m.op == ALU_SUB && ctrl_m.zsel == ZS_ZERO)
        |=> casc_out == PW'(-$past(mul_q)));

    a_r6_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
        (en_out && ctrl_m.op == ALU_ADD && ctrl_m.zsel == ZS_FEEDBACK)
        |=> casc_out == PW'($past(casc_out) + $past(mul_q)));

endmodule

bind preadd_mac_slice pmac_checker #(.PW(PW)) i_pmac_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_mul   (en_mul),
    .en_out   (en_out),
    .ctrl_m   (ctrl_m),
    .mul_q    (mul_q),
    .casc_out (casc_out)
);

// File: tb/test_preadd_mac_slice.sv
`timescale 1ns / 1ps
module test_preadd_mac_slice;

    typedef struct packed {
        logic [24:0] a;
        logic [24:0] d;
        logic [17:0] b;
        logic [47:0] c;
        logic [47:0] casc;
        logic [4:0]  mode;
        logic [47:0] exp;
    } vec_t;

    // a, d, b, c, casc, mode, expected
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{25'sd3,   25'sd2, 18'sd5,  48'sd0,    48'sd0,    5'b00000, 48'sd25},      // R3 add
        '{25'sd3,   25'sd2, 18'sd5,  48'sd0,    48'sd0,    5'b10000, 48'sd5},       // R3 sub
        '{-25'sd7,  25'sd0, 18'sd6,  48'sd1000, 48'sd0,    5'b01100, 48'sd958},     // R5 Z=C
        '{25'sd10,  25'sd0, 18'sd4,  48'sd100,  48'sd0,    5'b01111, 48'sd60},      // R4 Z-M
        '{25'sd10,  25'sd0, 18'sd4,  48'sd100,  48'sd0,    5'b01101, -48'sd60},     // R4 M-Z
        '{25'sd10,  25'sd0, 18'sd4,  48'sd100,  48'sd0,    5'b01110, -48'sd141},    // R4 not sum
        '{25'sd2,   25'sd3, -18'sd3, 48'sd0,    48'sd5000, 5'b00100, 48'sd4985},    // R5 casc
        '{25'h1000000, 25'h1000000, 18'h20000, 48'sd0, 48'sd0, 5'b00000, 48'h0400_0000_0000}, // R3 extremes
        '{25'sd1,   25'sd0, 18'sd1,  48'h7FFF_FFFF_FFFF, 48'sd0, 5'b01100, 48'h8000_0000_0000}, // R8 wrap
        '{-25'sd5,  25'sd7, -18'sd9, 48'sd0,    48'sd0,    5'b10000, 48'sd108}      // R3 neg sub
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_opnd = 1'b1, en_pre = 1'b1, en_mul = 1'b1, en_out = 1'b1;
    logic [24:0] a_in = '0, d_in = '0;
    logic [17:0] b_in = '0;
    logic [47:0] c_in = '0, casc_in = '0;
    logic [4:0]  mode = '0;
    logic [47:0] casc_out, casc_out_s;
    logic [47:0] p_out;
    logic [43:0] p_out_s;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    preadd_mac_slice i_preadd_mac_slice (
        .clk(clk), .rst_n(rst_n), .en_opnd(en_opnd), .en_pre(en_pre),
        .en_mul(en_mul), .en_out(en_out), .a_in(a_in), .d_in(d_in),
        .b_in(b_in), .c_in(c_in), .mode(mode), .casc_in(casc_in),
        .casc_out(casc_out), .p_out(p_out)
    );

    preadd_mac_slice #(.SHIFT(4)) i_preadd_mac_slice_shift (
        .clk(clk), .rst_n(rst_n), .en_opnd(en_opnd), .en_pre(en_pre),
        .en_mul(en_mul), .en_out(en_out), .a_in(a_in), .d_in(d_in),
        .b_in(b_in), .c_in(c_in), .mode(mode), .casc_in(casc_in),
        .casc_out(casc_out_s), .p_out(p_out_s)
    );

    task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        a_in = v.a; d_in = v.d; b_in = v.b; c_in = v.c;
        casc_in = v.casc; mode = v.mode;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 casc_out", casc_out, 48'd0);
        check("R1 p_out", p_out, 48'd0);
        rst_n = 1'b1;

        // R2: latency of four edges
        @(negedge clk);
        drive(VECS[0]);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R2 before 4th edge", casc_out, 48'd0);
        @(posedge clk);
        @(negedge clk);
        check("R2 after 4th edge", casc_out, 48'd25);

        // Table walk: one vector held for the pipeline depth (R3 R4 R5 R8 R10)
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            repeat (4) @(posedge clk);
            @(negedge clk);
            check($sformatf("R3/R4/R5/R8 vector %0d", i), casc_out, VECS[i].exp);
            check($sformatf("R10 p_out vector %0d", i), p_out, VECS[i].exp);
            check($sformatf("R10 shifted p_out vector %0d", i), {4'd0, p_out_s}, {4'd0, VECS[i].exp[47:4]});
        end

        // R7: back-to-back streaming with differing modes
        for (int i = 0; i < 10; i++) begin
            if (i >= 4) check($sformatf("R7 stream %0d", i - 4), casc_out, VECS[i-4].exp);
            if (i < 6) drive(VECS[i]);
            @(negedge clk);
        end

        // R6: restart with C, then accumulate
        a_in = 25'sd2; d_in = '0; b_in = 18'sd3; c_in = 48'sd10; casc_in = '0;
        mode = 5'b01100;
        @(negedge clk);
        mode = 5'b01000;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        check("R6 restart", casc_out, 48'sd16);
        @(negedge clk);
        check("R6 accumulate 1", casc_out, 48'sd22);
        @(negedge clk);
        check("R6 accumulate 2", casc_out, 48'sd28);

        // R9: operand stage enable held low
        drive(VECS[0]);
        repeat (5) @(negedge clk);
        check("R9 steady", casc_out, 48'sd25);
        en_opnd = 1'b0;
        drive(VECS[1]);
        repeat (6) @(negedge clk);
        check("R9 operand stage held", casc_out, 48'sd25);
        en_opnd = 1'b1;
        repeat (4) @(negedge clk);
        check("R9 operand stage released", casc_out, 48'sd5);

        // R9: product stage enable held low
        en_mul = 1'b0;
        drive(VECS[0]);
        repeat (6) @(negedge clk);
        check("R9 product stage held", casc_out, 48'sd5);
        en_mul = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 product stage released", casc_out, 48'sd25);

        // R9: result stage enable held low, bubbles downstream
        drive(VECS[1]);
        repeat (5) @(negedge clk);
        en_out = 1'b0;
        drive(VECS[0]);
        repeat (6) @(negedge clk);
        check("R9 result stage held", casc_out, 48'sd5);
        en_out = 1'b1;
        @(negedge clk);
        check("R9 result stage released", casc_out, 48'sd25);

        // R1: reset mid-run clears result
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset", casc_out, 48'd0);
        rst_n = 1'b1;

        done = 1'b1;
        summary();
        $finish;
    end

endmodule